// File: doc/BRIEF.md
# Masked Running Arg-Max

This unit sits at the end of a masked classifier datapath. It takes the final-layer scores one at a time, and each score arrives as two Boolean shares whose XOR is the signed score. The unit keeps the best score so far and the position of that score, and it holds both only as share pairs. When every score has been seen, it presents the two shares of the winning position. No clear value of a score, a comparison result or the winning class exists inside the unit.

Each comparison uses an external masked adder. The unit drives the sign-extended shares of the stored maximum and of the new score, with the subtract flag set. It waits a fixed adder latency and then takes the two most significant bit shares of the difference. Those two bits drive two masked selectors, one for the score and one for the index. Each selector computes `old XOR (sel AND (old XOR new))` per bit, using registered two-share AND cells that take one fresh random bit each. Fresh randomness comes in on a port on every cycle.

Top module: `masked_argmax`

## Requirements
- R1: After reset, `done` and `add_issue` are low, `score_ready` is high, and both index share outputs are zero.
- R2: `score_ready` is low while a comparison is in progress, and a `score_valid` presented while `score_ready` is low is ignored. It neither alters the result nor shortens the comparison.
- R3: The first score of a run (after reset or after `done`) is stored as the maximum with index 0, and no adder operation is issued for it. `score_ready` stays high after it.
- R4: Each later score causes exactly one adder issue, with `add_sub` high. At issue, the XOR of the A shares equals the sign-extended running maximum, and the XOR of the B shares equals the sign-extended new score. A run of N_SCORES scores therefore issues N_SCORES-1 operations.
- R5: `add_issue` is a single-cycle pulse. The difference shares are sampled ADD_LAT+1 cycles after the issue cycle.
- R6: If the XOR of the two difference MSB shares is 1, the new score and its position replace the stored ones. Otherwise, including on equal scores, the stored pair is kept, so ties resolve to the earlier position.
- R7: `done` rises once the update for score number N_SCORES is committed, and it stays high with `score_ready` high. The next accepted score starts a new run and drops `done`.
- R8: While `done` is high, the XOR of `idx_s0` and `idx_s1` equals the position (0-based, in arrival order) of the greatest score.
- R9: A compared score keeps `score_ready` low for exactly ADD_LAT+3 cycles after the cycle it is accepted in.
- R10: Comparisons are correct over the full signed range of SCORE_W-bit scores, including the most positive value against the most negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| score_valid | input | 1 | A score share pair is offered |
| score_s0 | input | SCORE_W | Score share 0 |
| score_s1 | input | SCORE_W | Score share 1 |
| score_ready | output | 1 | The unit takes a score this cycle if valid |
| rnd | input | SCORE_W+2*IDX_W | Fresh random bits, new every cycle |
| add_a_s0 | output | SCORE_W+1 | Adder operand A share 0 (maximum) |
| add_a_s1 | output | SCORE_W+1 | Adder operand A share 1 |
| add_b_s0 | output | SCORE_W+1 | Adder operand B share 0 (new score) |
| add_b_s1 | output | SCORE_W+1 | Adder operand B share 1 |
| add_sub | output | 1 | Adder subtract mode |
| add_issue | output | 1 | Operands are valid from this cycle |
| add_msb_s0 | input | 1 | Difference MSB share 0 |
| add_msb_s1 | input | 1 | Difference MSB share 1 |
| done | output | 1 | The winning index shares are final |
| idx_s0 | output | IDX_W | Winning index share 0 |
| idx_s1 | output | IDX_W | Winning index share 1 |

## Verification
The hardest situations to reach are the ones where the selector's decision comes down to a single sign bit under masking. These are exact ties, and a maximum at one end of the signed range compared with a score at the other end, where a difference with no extra bit would wrap. The stimulus builds score sets on purpose: all scores equal, a strictly rising sequence, repeated maxima, and extreme values placed next to each other. The bench's adder model remasks every difference with a fresh random share, so a wrong share combination in the unit shows up as a wrong index. A spurious score is pulsed in the middle of a comparison to show that it is ignored.

// File: rtl/argmax_pkg.sv
package argmax_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GET,
        ST_ADD,
        ST_SEL,
        ST_COMMIT,
        ST_DONE
    } argmax_st_e;

endpackage

// File: rtl/masked_and.sv
// Two-share AND with every cross product registered before recombination.
module masked_and (
    input  logic clk,
    input  logic rst_n,
    input  logic x0,
    input  logic x1,
    input  logic y0,
    input  logic y1,
    input  logic r,
    output logic z0,
    output logic z1
);

    typedef struct packed {
        logic rr;
        logic p00;
        logic p01;
        logic p10;
        logic p11;
    } and_regs_t;

    and_regs_t t_d, t_q;

    always_comb begin
        t_d.rr  = r;
        t_d.p00 = x0 & y0;
        t_d.p01 = x0 & y1;
        t_d.p10 = x1 & y0;
        t_d.p11 = x1 & y1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // share 0 is pure randomness; share 1 folds the four products onto it
    assign z0 = t_q.rr;
    assign z1 = t_q.rr ^ t_q.p00 ^ t_q.p01 ^ t_q.p10 ^ t_q.p11;

    // R6: one cycle later the output shares encode the product of the inputs
    a_r6_and_product: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((z0 ^ z1) == $past((x0 ^ x1) & (y0 ^ y1))));

endmodule

// File: rtl/masked_mux.sv
// Shared selector: out = old ^ (sel & (old ^ new)), bit by bit on shares.
module masked_mux #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] old_s0,
    input  logic [W-1:0] old_s1,
    input  logic [W-1:0] new_s0,
    input  logic [W-1:0] new_s1,
    input  logic         sel_s0,
    input  logic         sel_s1,
    input  logic [W-1:0] rnd,
    output logic [W-1:0] out_s0,
    output logic [W-1:0] out_s1
);

    logic [W-1:0] dif_s0, dif_s1;
    logic [W-1:0] and_s0, and_s1;

    assign dif_s0 = old_s0 ^ new_s0;
    assign dif_s1 = old_s1 ^ new_s1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        masked_and u_and (
            .clk   (clk),
            .rst_n (rst_n),
            .x0    (sel_s0),
            .x1    (sel_s1),
            .y0    (dif_s0[b]),
            .y1    (dif_s1[b]),
            .r     (rnd[b]),
            .z0    (and_s0[b]),
            .z1    (and_s1[b])
        );
    end

    assign out_s0 = old_s0 ^ and_s0;
    assign out_s1 = old_s1 ^ and_s1;

    // R6: a clear-zero select leaves the old value in place
    a_r6_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_s0 ^ sel_s1) == 1'b0) |=> ((out_s0 ^ out_s1) == (old_s0 ^ old_s1)));

    // R6: a clear-one select swaps in the new value (old may move meanwhile)
    a_r6_take_new: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_s0 ^ sel_s1) == 1'b1) |=>
        ((out_s0 ^ out_s1) == ((old_s0 ^ old_s1) ^ $past(old_s0 ^ old_s1) ^ $past(new_s0 ^ new_s1))));

endmodule

// File: rtl/argmax_seq.sv
// Sequencer and share registers of the running arg-max.
module argmax_seq
    import argmax_pkg::*;
#(
    parameter int SCORE_W  = 16,
    parameter int N_SCORES = 10,
    parameter int ADD_LAT  = 4,
    localparam int AW  = SCORE_W + 1,
    localparam int IW  = (N_SCORES > 1) ? $clog2(N_SCORES) : 1,
    localparam int CNW = $clog2(N_SCORES + 1),
    localparam int CW  = $clog2(ADD_LAT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               score_valid,
    input  logic [SCORE_W-1:0] score_s0,
    input  logic [SCORE_W-1:0] score_s1,
    output logic               score_ready,
    input  logic [IW-1:0]      rnd_idx,
    output logic [AW-1:0]      add_a_s0,
    output logic [AW-1:0]      add_a_s1,
    output logic [AW-1:0]      add_b_s0,
    output logic [AW-1:0]      add_b_s1,
    output logic               add_sub,
    output logic               add_issue,
    input  logic               add_msb_s0,
    input  logic               add_msb_s1,
    output logic [SCORE_W-1:0] max_s0,
    output logic [SCORE_W-1:0] max_s1,
    output logic [SCORE_W-1:0] cand_s0,
    output logic [SCORE_W-1:0] cand_s1,
    output logic [IW-1:0]      cur_idx_s0,
    output logic [IW-1:0]      cur_idx_s1,
    output logic [IW-1:0]      cand_idx_s0,
    output logic [IW-1:0]      cand_idx_s1,
    output logic               sel_s0,
    output logic               sel_s1,
    input  logic [SCORE_W-1:0] upd_max_s0,
    input  logic [SCORE_W-1:0] upd_max_s1,
    input  logic [IW-1:0]      upd_idx_s0,
    input  logic [IW-1:0]      upd_idx_s1,
    output logic               done
);

    typedef struct packed {
        argmax_st_e         st;
        logic [SCORE_W-1:0] mx0;
        logic [SCORE_W-1:0] mx1;
        logic [SCORE_W-1:0] nw0;
        logic [SCORE_W-1:0] nw1;
        logic [IW-1:0]      ix0;
        logic [IW-1:0]      ix1;
        logic [IW-1:0]      nx0;
        logic [IW-1:0]      nx1;
        logic               sl0;
        logic               sl1;
        logic [CW-1:0]      wt;
        logic [CNW-1:0]     cnt;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      first_take;
    logic [CNW-1:0] cnt_inc;

    assign cnt_inc = r_q.cnt + CNW'(1);

    always_comb begin
        r_d         = r_q;
        score_ready = 1'b0;
        first_take  = 1'b0;
        case (r_q.st)
            ST_IDLE, ST_DONE: begin
                score_ready = 1'b1;
                if (score_valid) begin
                    first_take = 1'b1;
                    r_d.mx0 = score_s0;
                    r_d.mx1 = score_s1;
                    // position 0 carried as a pair of equal random shares
                    r_d.ix0 = rnd_idx;
                    r_d.ix1 = rnd_idx;
                    r_d.cnt = CNW'(1);
                    r_d.st  = (N_SCORES == 1) ? ST_DONE : ST_GET;
                end
            end
            ST_GET: begin
                score_ready = 1'b1;
                if (score_valid) begin
                    r_d.nw0 = score_s0;
                    r_d.nw1 = score_s1;
                    r_d.nx0 = IW'(r_q.cnt) ^ rnd_idx;
                    r_d.nx1 = rnd_idx;
                    r_d.wt  = '0;
                    r_d.st  = ST_ADD;
                end
            end
            ST_ADD: begin
                if (r_q.wt == CW'(ADD_LAT)) begin
                    r_d.sl0 = add_msb_s0;
                    r_d.sl1 = add_msb_s1;
                    r_d.st  = ST_SEL;
                end else begin
                    r_d.wt = r_q.wt + CW'(1);
                end
            end
            ST_SEL: begin
                r_d.st = ST_COMMIT;
            end
            ST_COMMIT: begin
                r_d.mx0 = upd_max_s0;
                r_d.mx1 = upd_max_s1;
                r_d.ix0 = upd_idx_s0;
                r_d.ix1 = upd_idx_s1;
                r_d.sl0 = 1'b0;
                r_d.sl1 = 1'b0;
                r_d.cnt = cnt_inc;
                r_d.st  = (cnt_inc == CNW'(N_SCORES)) ? ST_DONE : ST_GET;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // each share is sign-extended on its own; the XOR stays the extended value
    assign add_a_s0 = {r_q.mx0[SCORE_W-1], r_q.mx0};
    assign add_a_s1 = {r_q.mx1[SCORE_W-1], r_q.mx1};
    assign add_b_s0 = {r_q.nw0[SCORE_W-1], r_q.nw0};
    assign add_b_s1 = {r_q.nw1[SCORE_W-1], r_q.nw1};
    assign add_sub   = (r_q.st == ST_ADD);
    assign add_issue = (r_q.st == ST_ADD) && (r_q.wt == '0);

    assign max_s0      = r_q.mx0;
    assign max_s1      = r_q.mx1;
    assign cand_s0     = r_q.nw0;
    assign cand_s1     = r_q.nw1;
    assign cur_idx_s0  = r_q.ix0;
    assign cur_idx_s1  = r_q.ix1;
    assign cand_idx_s0 = r_q.nx0;
    assign cand_idx_s1 = r_q.nx1;
    assign sel_s0      = r_q.sl0;
    assign sel_s1      = r_q.sl1;
    assign done        = (r_q.st == ST_DONE);

    // R4: every issue is a subtraction
    a_r4_sub_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
        add_issue |-> add_sub);

    // R5: the issue strobe lasts one cycle
    a_r5_issue_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        add_issue |=> !add_issue);

    // R2: no score is taken while an operation is in flight
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        add_sub |-> !score_ready);

    // R3: a first score is never followed by an adder issue
    a_r3_first_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        first_take |=> !add_issue);

    // R7: done holds until a new score is accepted, and the unit stays ready
    a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !score_valid) |=> (done && score_ready));

endmodule

// File: rtl/masked_argmax.sv
module masked_argmax #(
    parameter int SCORE_W  = 16,
    parameter int N_SCORES = 10,
    parameter int ADD_LAT  = 4,
    localparam int AW  = SCORE_W + 1,
    localparam int IW  = (N_SCORES > 1) ? $clog2(N_SCORES) : 1,
    localparam int RW  = SCORE_W + 2 * IW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               score_valid,
    input  logic [SCORE_W-1:0] score_s0,
    input  logic [SCORE_W-1:0] score_s1,
    output logic               score_ready,
    input  logic [RW-1:0]      rnd,
    output logic [AW-1:0]      add_a_s0,
    output logic [AW-1:0]      add_a_s1,
    output logic [AW-1:0]      add_b_s0,
    output logic [AW-1:0]      add_b_s1,
    output logic               add_sub,
    output logic               add_issue,
    input  logic               add_msb_s0,
    input  logic               add_msb_s1,
    output logic               done,
    output logic [IW-1:0]      idx_s0,
    output logic [IW-1:0]      idx_s1
);

    logic [SCORE_W-1:0] max_s0, max_s1, cand_s0, cand_s1;
    logic [SCORE_W-1:0] upd_max_s0, upd_max_s1;
    logic [IW-1:0]      cand_idx_s0, cand_idx_s1, upd_idx_s0, upd_idx_s1;
    logic               sel_s0, sel_s1;

    argmax_seq #(
        .SCORE_W  (SCORE_W),
        .N_SCORES (N_SCORES),
        .ADD_LAT  (ADD_LAT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .score_valid (score_valid),
        .score_s0    (score_s0),
        .score_s1    (score_s1),
        .score_ready (score_ready),
        .rnd_idx     (rnd[SCORE_W+IW +: IW]),
        .add_a_s0    (add_a_s0),
        .add_a_s1    (add_a_s1),
        .add_b_s0    (add_b_s0),
        .add_b_s1    (add_b_s1),
        .add_sub     (add_sub),
        .add_issue   (add_issue),
        .add_msb_s0  (add_msb_s0),
        .add_msb_s1  (add_msb_s1),
        .max_s0      (max_s0),
        .max_s1      (max_s1),
        .cand_s0     (cand_s0),
        .cand_s1     (cand_s1),
        .cur_idx_s0  (idx_s0),
        .cur_idx_s1  (idx_s1),
        .cand_idx_s0 (cand_idx_s0),
        .cand_idx_s1 (cand_idx_s1),
        .sel_s0      (sel_s0),
        .sel_s1      (sel_s1),
        .upd_max_s0  (upd_max_s0),
        .upd_max_s1  (upd_max_s1),
        .upd_idx_s0  (upd_idx_s0),
        .upd_idx_s1  (upd_idx_s1),
        .done        (done)
    );

    masked_mux #(.W(SCORE_W)) u_mux_max (
        .clk    (clk),
        .rst_n  (rst_n),
        .old_s0 (max_s0),
        .old_s1 (max_s1),
        .new_s0 (cand_s0),
        .new_s1 (cand_s1),
        .sel_s0 (sel_s0),
        .sel_s1 (sel_s1),
        .rnd    (rnd[SCORE_W-1:0]),
        .out_s0 (upd_max_s0),
        .out_s1 (upd_max_s1)
    );

    masked_mux #(.W(IW)) u_mux_idx (
        .clk    (clk),
        .rst_n  (rst_n),
        .old_s0 (idx_s0),
        .old_s1 (idx_s1),
        .new_s0 (cand_idx_s0),
        .new_s1 (cand_idx_s1),
        .sel_s0 (sel_s0),
        .sel_s1 (sel_s1),
        .rnd    (rnd[SCORE_W +: IW]),
        .out_s0 (upd_idx_s0),
        .out_s1 (upd_idx_s1)
    );

endmodule

// File: tb/masked_argmax_tb.sv
module masked_argmax_tb;

    localparam int SW = 16;
    localparam int N  = 10;
    localparam int L  = 4;
    localparam int AW = SW + 1;
    localparam int IW = $clog2(N);
    localparam int RW = SW + 2 * IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          score_valid = 1'b0;
    logic [SW-1:0] score_s0 = '0, score_s1 = '0;
    logic          score_ready;
    logic [RW-1:0] rnd = '0;
    logic [AW-1:0] add_a_s0, add_a_s1, add_b_s0, add_b_s1;
    logic          add_sub, add_issue, add_msb_s0, add_msb_s1;
    logic          done;
    logic [IW-1:0] idx_s0, idx_s1;

    int checks = 0;
    int failures = 0;
    int issues = 0;
    int ref_max, ref_idx, cur_score;

    always #10 clk = ~clk;

    masked_argmax #(.SCORE_W(SW), .N_SCORES(N), .ADD_LAT(L)) u_dut (
        .clk(clk), .rst_n(rst_n), .score_valid(score_valid),
        .score_s0(score_s0), .score_s1(score_s1), .score_ready(score_ready),
        .rnd(rnd), .add_a_s0(add_a_s0), .add_a_s1(add_a_s1),
        .add_b_s0(add_b_s0), .add_b_s1(add_b_s1), .add_sub(add_sub),
        .add_issue(add_issue), .add_msb_s0(add_msb_s0), .add_msb_s1(add_msb_s1),
        .done(done), .idx_s0(idx_s0), .idx_s1(idx_s1)
    );

    // behavioural masked adder: L-stage delay, every result remasked
    logic [AW-1:0] pv [L];
    logic [AW-1:0] pm [L];
    initial for (int i = 0; i < L; i++) begin pv[i] = '0; pm[i] = '0; end
    always @(posedge clk) begin
        for (int i = L - 1; i > 0; i--) begin
            pv[i] <= pv[i-1];
            pm[i] <= pm[i-1];
        end
        pv[0] <= add_sub ? ((add_a_s0 ^ add_a_s1) - (add_b_s0 ^ add_b_s1))
                         : ((add_a_s0 ^ add_a_s1) + (add_b_s0 ^ add_b_s1));
        pm[0] <= AW'($urandom);
    end
    assign add_msb_s0 = pm[L-1][AW-1];
    assign add_msb_s1 = pm[L-1][AW-1] ^ pv[L-1][AW-1];

    always @(negedge clk) rnd <= RW'({$urandom, $urandom});

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sx(input logic [AW-1:0] v);
        return int'($signed(v));
    endfunction

    // R4: operands seen at each issue
    always @(negedge clk) begin
        if (rst_n && add_issue) begin
            issues++;
            chk(add_sub == 1'b1, "R4", "sub flag at issue", add_sub, 1);
            chk(sx(add_a_s0 ^ add_a_s1) == ref_max, "R4", "operand A", sx(add_a_s0 ^ add_a_s1), ref_max);
            chk(sx(add_b_s0 ^ add_b_s1) == cur_score, "R4", "operand B", sx(add_b_s0 ^ add_b_s1), cur_score);
        end
    end

    task automatic feed(input int v, input int pos, input bit poke);
        logic [SW-1:0] m;
        int lat;
        m = SW'($urandom);
        @(negedge clk);
        chk(score_ready == 1'b1, "R2", "ready before offer", score_ready, 1);
        cur_score = v;
        score_valid = 1'b1;
        score_s0 = m;
        score_s1 = SW'(v) ^ m;
        @(negedge clk);
        score_valid = 1'b0;
        lat = 0;
        while (!score_ready && lat < 100) begin
            chk(done == 1'b0, "R7", "done low while busy", done, 0);
            if (poke && lat == 1) begin
                // R2: spurious score during a compare must be ignored
                score_valid = 1'b1;
                score_s0 = SW'($urandom);
                score_s1 = score_s0 ^ SW'(32767);
            end else begin
                score_valid = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        score_valid = 1'b0;
        if (pos == 0) begin
            chk(lat == 0, "R3", "first score needs no compare", lat, 0);
            chk(issues == 0, "R3", "no issue for first score", issues, 0);
            chk(done == 1'b0, "R7", "done drops on new run", done, 0);
            ref_max = v;
            ref_idx = 0;
        end else begin
            chk(lat == L + 3, "R9", "busy cycles per compare", lat, L + 3);
            if (v > ref_max) begin
                ref_max = v;
                ref_idx = pos;
            end
        end
    endtask

    task automatic run(input int sc [N], input bit poke, input string tag);
        issues = 0;
        for (int p = 0; p < N; p++) feed(sc[p], p, poke);
        chk(done == 1'b1, "R7", {"done after last score ", tag}, done, 1);
        chk(score_ready == 1'b1, "R7", "ready while done", score_ready, 1);
        chk(issues == N - 1, "R4", "adder issues per run", issues, N - 1);
        chk(int'(idx_s0 ^ idx_s1) == ref_idx, "R8", {"winning index ", tag},
            int'(idx_s0 ^ idx_s1), ref_idx);
        repeat (2) @(negedge clk);
        chk(done == 1'b1 && int'(idx_s0 ^ idx_s1) == ref_idx, "R7",
            "result held while idle", int'(idx_s0 ^ idx_s1), ref_idx);
    endtask

    function automatic int rs();
        return int'($signed(SW'($urandom)));
    endfunction

    initial begin
        int sc [N];
        ref_max = 0; ref_idx = 0; cur_score = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 1'b0, "R1", "done at reset", done, 0);
        chk(score_ready == 1'b1, "R1", "ready at reset", score_ready, 1);
        chk(add_issue == 1'b0, "R1", "issue at reset", add_issue, 0);
        chk(idx_s0 == '0 && idx_s1 == '0, "R1", "index shares at reset",
            int'({idx_s0, idx_s1}), 0);
        rst_n = 1'b1;

        for (int k = 0; k < N; k++) sc[k] = rs();
        run(sc, 1'b0, "random");

        for (int k = 0; k < N; k++) sc[k] = 123;   // R6: all ties keep 0
        run(sc, 1'b0, "all equal");

        for (int k = 0; k < N; k++) sc[k] = k * 100 - 400;
        run(sc, 1'b0, "rising");

        for (int k = 0; k < N; k++) sc[k] = 900 - k;
        run(sc, 1'b1, "falling with poke");

        // R10: extreme values next to each other
        for (int k = 0; k < N; k++) sc[k] = -32768;
        sc[4] = 32767; sc[5] = -32768; sc[8] = 32767;
        run(sc, 1'b0, "extremes tie");

        for (int k = 0; k < N; k++) sc[k] = (k % 2 == 0) ? -32768 : -32767;
        sc[0] = 32767;
        run(sc, 1'b0, "max first");

        for (int k = 0; k < N; k++) sc[k] = -5;   // R6: repeated maximum
        sc[3] = 40; sc[7] = 40;
        run(sc, 1'b0, "duplicate max");

        for (int r = 0; r < 6; r++) begin
            for (int k = 0; k < N; k++) sc[k] = rs();
            run(sc, r[0], "random mix");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule